// File: doc/BRIEF.md
# Deferred exception token tracker

This block keeps a small register file in which every entry carries a one-bit deferred-exception token next to its data. With the token, a load can be hoisted above a branch and executed speculatively. If that load would fault, the fault is not raised. The load's destination register is tagged instead.

The token travels with the data. Any write whose source operands include a tagged register produces a tagged result, and whatever fault that write would itself have caused is also suppressed. A faulting write that is not speculative and reads only clean sources still raises its fault, as a one-cycle pulse. A write with a clean result and clean sources clears the token of its destination.

A check port looks at one register's token. If the token is clear, the check does nothing. If it is set, the block emits a one-cycle redirect that carries the recovery address supplied with the check. Because tokens propagate along dependences, one check on the last register of a dependent chain covers every speculative step before it. The block does not perform the memory access, the arithmetic, or the fetch of the recovery code. The caller only tells it whether a write is speculative and whether that write would fault.

Top module: `dx_tracker`

## Requirements
- R1: During reset every token and data word is cleared, and `redir_vld` and `fault_raise` are held low.
- R2: A write with `wr_spec`=1 and `wr_fault`=1 stores its data and sets the token of register `wr_idx`. `fault_raise` stays low in the following cycle.
- R3: A write that has any source with `src_vld[k]`=1 whose register `src_idx[k]` holds a set token sets its destination's token, whether or not it is speculative. Its own fault is suppressed: `fault_raise` stays low in the following cycle.
- R4: A write with `wr_fault`=0 and no tagged valid source clears its destination's token.
- R5: A write with `wr_spec`=0 and `wr_fault`=1 and no tagged valid source stores its data with a clear token and pulses `fault_raise` high for exactly the following cycle.
- R6: A check (`chk_vld`=1) on a register whose token is clear gives `redir_vld`=0 in the following cycle.
- R7: A check on a register whose token is set gives `redir_vld`=1 in the following cycle, with `redir_target` equal to the `chk_target` of the check. The pulse lasts one cycle unless the next cycle holds another such check.
- R8: A check and a write of the same register in the same cycle see the token produced by that write, whether the write sets it or clears it.
- R9: A check on the last register of a chain of dependent writes redirects when any earlier step of the chain was a deferred fault.
- R10: Read port r returns the data and token of register `rd_idx[r]` as held after the last clock edge. Source tokens are sampled from the state before the current cycle's write.
- R11: With `wr_en`=0 no register changes. A source with `src_vld[k]`=0 contributes no token. Without `chk_vld`, `redir_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | IDXW | Destination register index |
| wr_data | input | XLEN | Result data to store |
| wr_spec | input | 1 | Writing instruction is speculative |
| wr_fault | input | 1 | Writing instruction would fault |
| src_vld | input | NSRC | Per-source valid flags of the writing instruction |
| src_idx | input | NSRC x IDXW | Source register indices of the writing instruction |
| rd_idx | input | NRD x IDXW | Read port register indices |
| rd_data | output | NRD x XLEN | Read port data |
| rd_tok | output | NRD | Read port tokens |
| chk_vld | input | 1 | Check request |
| chk_idx | input | IDXW | Register to check |
| chk_target | input | XLEN | Recovery address of the check |
| redir_vld | output | 1 | Redirect pulse, one cycle after a failing check |
| redir_target | output | XLEN | Recovery address of the redirect |
| fault_raise | output | 1 | Pulse for a fault that is not deferred |

## Verification
The bench builds the block with its default values: eight registers of 32 bits, two read ports and two sources per write. With only eight indices, random writes, sources and checks collide on the same register often. Same-cycle write/check bypasses in both directions, tokens inherited through either source, and long dependent chains therefore all occur many times within a few thousand cycles. Directed sequences add the reset state, a three-step chain resolved by one check, and bypasses that set and clear the token.

// File: rtl/dx_pkg.sv
package dx_pkg;

    // Outcome of one write request with respect to the token it leaves behind.
    typedef enum logic [2:0] {
        WK_IDLE    = 3'd0,  // no write
        WK_CLEAN   = 3'd1,  // exception-free, clean sources: token cleared
        WK_DEFER   = 3'd2,  // speculative fault: token set, fault hidden
        WK_INHERIT = 3'd3,  // tagged source: token set, any fault hidden
        WK_RAISE   = 3'd4   // non-speculative fault, clean sources: raised
    } wr_kind_e;

    function automatic wr_kind_e dx_classify(
        input logic en,
        input logic spec,
        input logic fault,
        input logic tainted
    );
        wr_kind_e k;
        if (!en)
            k = WK_IDLE;
        else if (tainted)
            k = WK_INHERIT;
        else if (fault && spec)
            k = WK_DEFER;
        else if (fault)
            k = WK_RAISE;
        else
            k = WK_CLEAN;
        return k;
    endfunction

    function automatic logic dx_kind_tok(input wr_kind_e k);
        return (k == WK_DEFER) || (k == WK_INHERIT);
    endfunction

endpackage

// File: rtl/dx_regfile.sv
module dx_regfile #(
    parameter int NREG = 8,
    parameter int XLEN = 32,
    parameter int NRD  = 2,
    parameter int NSRC = 2,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDXW-1:0]                widx,
    input  logic [XLEN-1:0]                wdata,
    input  logic                           wtok,
    input  logic [NRD-1:0][IDXW-1:0]       rd_idx,
    output logic [NRD-1:0][XLEN-1:0]       rd_data,
    output logic [NRD-1:0]                 rd_tok,
    input  logic [NSRC-1:0][IDXW-1:0]      src_idx,
    output logic [NSRC-1:0]                src_tok,
    output logic [NREG-1:0]                marker_vec
);

    logic [XLEN-1:0] data_q [NREG];
    logic [NREG-1:0] tok_q;

    for (genvar e = 0; e < NREG; e++) begin : g_entry
        logic hit;
        assign hit = we && (widx == IDXW'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[e] <= '0;
                tok_q[e]  <= 1'b0;
            end else if (hit) begin
                data_q[e] <= wdata;
                tok_q[e]  <= wtok;
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = data_q[rd_idx[r]];
        assign rd_tok[r]  = tok_q[rd_idx[r]];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_tok[s] = tok_q[src_idx[s]];
    end

    assign marker_vec = tok_q;

endmodule

// File: rtl/dx_wr_class.sv
module dx_wr_class #(
    parameter int NSRC = 2
) (
    input  logic            wr_en,
    input  logic            wr_spec,
    input  logic            wr_fault,
    input  logic [NSRC-1:0] src_vld,
    input  logic [NSRC-1:0] src_tok,
    output dx_pkg::wr_kind_e kind,
    output logic            new_tok,
    output logic            raise_now
);
    import dx_pkg::*;

    logic [NSRC-1:0] src_hot;
    logic            tainted;

    for (genvar s = 0; s < NSRC; s++) begin : g_hot
        assign src_hot[s] = src_vld[s] && src_tok[s];
    end

    assign tainted   = |src_hot;
    assign kind      = dx_classify(wr_en, wr_spec, wr_fault, tainted);
    assign new_tok   = dx_kind_tok(kind);
    assign raise_now = (kind == WK_RAISE);

endmodule

// File: rtl/dx_check.sv
module dx_check #(
    parameter int NREG = 8,
    parameter int XLEN = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chk_vld,
    input  logic [IDXW-1:0] chk_idx,
    input  logic [XLEN-1:0] chk_target,
    input  logic [NREG-1:0] marker_vec,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_tok,
    output logic            redir_vld,
    output logic [XLEN-1:0] redir_target
);

    logic tok_seen;

    // Same-cycle write to the checked register wins over the stored token.
    always_comb begin
        if (wr_en && (wr_idx == chk_idx))
            tok_seen = wr_tok;
        else
            tok_seen = marker_vec[chk_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_vld    <= 1'b0;
            redir_target <= '0;
        end else begin
            redir_vld <= chk_vld && tok_seen;
            if (chk_vld)
                redir_target <= chk_target;
        end
    end

endmodule

// File: rtl/dx_tracker.sv
module dx_tracker #(
    parameter int NREG = 8,
    parameter int XLEN = 32,
    parameter int NRD  = 2,
    parameter int NSRC = 2,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic                      wr_spec,
    input  logic                      wr_fault,
    input  logic [NSRC-1:0]           src_vld,
    input  logic [NSRC-1:0][IDXW-1:0] src_idx,
    input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0][XLEN-1:0]  rd_data,
    output logic [NRD-1:0]            rd_tok,
    input  logic                      chk_vld,
    input  logic [IDXW-1:0]           chk_idx,
    input  logic [XLEN-1:0]           chk_target,
    output logic                      redir_vld,
    output logic [XLEN-1:0]           redir_target,
    output logic                      fault_raise
);

    logic [NSRC-1:0]  src_tok;
    logic [NREG-1:0]  marker_vec;
    dx_pkg::wr_kind_e wr_kind;
    logic             new_tok;
    logic             raise_now;

    dx_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD), .NSRC(NSRC)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_en),
        .widx       (wr_idx),
        .wdata      (wr_data),
        .wtok       (new_tok),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .rd_tok     (rd_tok),
        .src_idx    (src_idx),
        .src_tok    (src_tok),
        .marker_vec (marker_vec)
    );

    dx_wr_class #(.NSRC(NSRC)) u_cls (
        .wr_en     (wr_en),
        .wr_spec   (wr_spec),
        .wr_fault  (wr_fault),
        .src_vld   (src_vld),
        .src_tok   (src_tok),
        .kind      (wr_kind),
        .new_tok   (new_tok),
        .raise_now (raise_now)
    );

    dx_check #(.NREG(NREG), .XLEN(XLEN)) u_chk_unit (
        .clk          (clk),
        .rst          (rst),
        .chk_vld      (chk_vld),
        .chk_idx      (chk_idx),
        .chk_target   (chk_target),
        .marker_vec   (marker_vec),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tok       (new_tok),
        .redir_vld    (redir_vld),
        .redir_target (redir_target)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fault_raise <= 1'b0;
        else
            fault_raise <= raise_now;
    end

endmodule

// File: rtl/dx_tracker_chk.sv
module dx_tracker_chk #(
    parameter int NREG = 8,
    parameter int XLEN = 32,
    parameter int NSRC = 2,
    localparam int IDXW = $clog2(NREG)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [IDXW-1:0]           wr_idx,
    input logic                      wr_spec,
    input logic                      wr_fault,
    input logic [NSRC-1:0]           src_vld,
    input logic [NSRC-1:0][IDXW-1:0] src_idx,
    input logic                      chk_vld,
    input logic [IDXW-1:0]           chk_idx,
    input logic [XLEN-1:0]           chk_target,
    input logic                      redir_vld,
    input logic [XLEN-1:0]           redir_target,
    input logic                      fault_raise,
    input logic [NREG-1:0]           marker_vec
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: state after reset
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            a_r1_reset_clear: assert (marker_vec == '0 && !redir_vld && !fault_raise)
                else $error("reset state not clear");
        end
    end

    a_r2_defer_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_spec && wr_fault) |=> (marker_vec[$past(wr_idx)] && !fault_raise));

    a_r3_inherit_src0: assert property (@(posedge clk) disable iff (rst)
        (wr_en && src_vld[0] && marker_vec[src_idx[0]]) |=> (marker_vec[$past(wr_idx)] && !fault_raise));

    a_r5_raise_source: assert property (@(posedge clk) disable iff (rst)
        fault_raise |-> $past(wr_en && !wr_spec && wr_fault));

    // R6, R7, R8: the redirect matches the token the checked register now holds
    a_r7_redir_matches_token: assert property (@(posedge clk) disable iff (rst)
        chk_vld |=> (redir_vld == marker_vec[$past(chk_idx)]));

    a_r7_target: assert property (@(posedge clk) disable iff (rst)
        (chk_vld && !rst) |=> (!redir_vld || redir_target == $past(chk_target)));

    a_r11_no_check_no_redir: assert property (@(posedge clk) disable iff (rst)
        !chk_vld |=> !redir_vld);

    a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(marker_vec));

endmodule

bind dx_tracker dx_tracker_chk #(.NREG(NREG), .XLEN(XLEN), .NSRC(NSRC)) u_dx_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_spec      (wr_spec),
    .wr_fault     (wr_fault),
    .src_vld      (src_vld),
    .src_idx      (src_idx),
    .chk_vld      (chk_vld),
    .chk_idx      (chk_idx),
    .chk_target   (chk_target),
    .redir_vld    (redir_vld),
    .redir_target (redir_target),
    .fault_raise  (fault_raise),
    .marker_vec   (marker_vec)
);

// File: tb/test_dx_tracker.sv
module test_dx_tracker;

    localparam int NREG = 8;
    localparam int XLEN = 32;
    localparam int NRD  = 2;
    localparam int NSRC = 2;
    localparam int IDXW = $clog2(NREG);

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      wr_en, wr_spec, wr_fault;
    logic [IDXW-1:0]           wr_idx;
    logic [XLEN-1:0]           wr_data;
    logic [NSRC-1:0]           src_vld;
    logic [NSRC-1:0][IDXW-1:0] src_idx;
    logic [NRD-1:0][IDXW-1:0]  rd_idx;
    logic [NRD-1:0][XLEN-1:0]  rd_data;
    logic [NRD-1:0]            rd_tok;
    logic                      chk_vld;
    logic [IDXW-1:0]           chk_idx;
    logic [XLEN-1:0]           chk_target;
    logic                      redir_vld;
    logic [XLEN-1:0]           redir_target;
    logic                      fault_raise;

    always #2 clk = ~clk;  // 250 MHz

    dx_tracker #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD), .NSRC(NSRC)) i_dx_tracker (.*);

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [XLEN-1:0] m_data [NREG];
    logic            m_tok  [NREG];

    function automatic void chk(input logic ok, input string req, input string what,
                                input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic logic m_taint(input logic [NSRC-1:0] sv, input logic [NSRC-1:0][IDXW-1:0] si);
        logic t = 1'b0;
        for (int s = 0; s < NSRC; s++)
            if (sv[s] && m_tok[si[s]]) t = 1'b1;
        return t;
    endfunction

    task automatic step(input logic en, input logic [IDXW-1:0] idx, input logic [XLEN-1:0] data,
                        input logic spec, input logic fault,
                        input logic [NSRC-1:0] sv, input logic [NSRC-1:0][IDXW-1:0] si,
                        input logic cv, input logic [IDXW-1:0] ci, input logic [XLEN-1:0] ct,
                        input logic [IDXW-1:0] r1);
        logic taint, ntok, eraise, ctok, eredir;
        string tg;
        @(negedge clk);
        wr_en = en; wr_idx = idx; wr_data = data; wr_spec = spec; wr_fault = fault;
        src_vld = sv; src_idx = si; chk_vld = cv; chk_idx = ci; chk_target = ct;
        rd_idx[0] = idx; rd_idx[1] = r1;
        taint  = m_taint(sv, si);
        ntok   = taint || (spec && fault);
        eraise = en && !taint && fault && !spec;
        ctok   = (en && idx == ci) ? ntok : m_tok[ci];
        eredir = cv && ctok;
        @(posedge clk);
        #1;
        if (en) begin
            m_data[idx] = data;
            m_tok[idx]  = ntok;
        end
        if (!cv) tg = "R11";
        else if (en && idx == ci) tg = "R8";
        else if (ctok) tg = "R7";
        else tg = "R6";
        chk(redir_vld == eredir, tg, "redir_vld", XLEN'(redir_vld), XLEN'(eredir));
        if (eredir)
            chk(redir_target == ct, "R7", "redir_target", redir_target, ct);
        if (!en) tg = "R11";
        else if (taint) tg = "R3";
        else if (spec && fault) tg = "R2";
        else if (fault) tg = "R5";
        else tg = "R4";
        chk(fault_raise == eraise, tg, "fault_raise", XLEN'(fault_raise), XLEN'(eraise));
        chk(rd_tok[0] == m_tok[idx], tg, "token of written reg", XLEN'(rd_tok[0]), XLEN'(m_tok[idx]));
        chk(rd_data[0] == m_data[idx], "R10", "data port0", rd_data[0], m_data[idx]);
        chk(rd_data[1] == m_data[r1] && rd_tok[1] == m_tok[r1], "R10", "port1",
            {rd_tok[1], rd_data[1][XLEN-2:0]}, {m_tok[r1], m_data[r1][XLEN-2:0]});
    endtask

    // Same write/check with no other activity, for the directed parts.
    task automatic wr(input logic [IDXW-1:0] idx, input logic [XLEN-1:0] data, input logic spec,
                      input logic fault, input logic [NSRC-1:0] sv, input logic [IDXW-1:0] s0,
                      input logic [IDXW-1:0] s1);
        step(1'b1, idx, data, spec, fault, sv, {s1, s0}, 1'b0, '0, '0, '0);
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_0d1f));
        rst = 1'b1;
        wr_en = 0; wr_idx = '0; wr_data = '0; wr_spec = 0; wr_fault = 0;
        src_vld = '0; src_idx = '0; rd_idx = '0; chk_vld = 0; chk_idx = '0; chk_target = '0;
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_tok[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: every register reads zero with a clear token
        for (int i = 0; i < NREG; i++) begin
            rd_idx[0] = IDXW'(i);
            #1;
            chk(rd_tok[0] == 1'b0 && rd_data[0] == '0, "R1", "reset entry",
                {rd_tok[0], rd_data[0][XLEN-2:0]}, '0);
        end
        chk(!redir_vld && !fault_raise, "R1", "reset outputs",
            XLEN'({redir_vld, fault_raise}), '0);

        // R9: chain r1 <- deferred fault, r2 <- r1, r3 <- r2, one check on r3
        wr(3'd1, 32'h1111, 1'b1, 1'b1, 2'b00, 3'd0, 3'd0);
        wr(3'd2, 32'h2222, 1'b0, 1'b0, 2'b01, 3'd1, 3'd0);
        wr(3'd3, 32'h3333, 1'b0, 1'b1, 2'b10, 3'd0, 3'd2);
        step(1'b0, 3'd0, '0, 0, 0, 2'b00, '0, 1'b1, 3'd3, 32'hCAFE_0000, 3'd3);
        chk(m_tok[3] == 1'b1, "R9", "chain token", XLEN'(rd_tok[1]), 32'd1);
        // R8: clear r3 and check it in the same cycle; then set r4 and check it
        step(1'b1, 3'd3, 32'h4, 0, 0, 2'b00, '0, 1'b1, 3'd3, 32'hBEEF, 3'd3);
        step(1'b1, 3'd4, 32'h5, 1, 1, 2'b00, '0, 1'b1, 3'd4, 32'hF00D, 3'd4);
        // R11: invalid source that is tagged contributes nothing
        wr(3'd5, 32'h6, 1'b0, 1'b0, 2'b00, 3'd4, 3'd1);
        // R5: non-speculative fault with clean sources
        wr(3'd6, 32'h7, 1'b0, 1'b1, 2'b11, 3'd5, 3'd0);

        for (int n = 0; n < 3000; n++) begin
            logic [NSRC-1:0][IDXW-1:0] si;
            for (int s = 0; s < NSRC; s++) si[s] = IDXW'($urandom);
            step(($urandom % 4) != 0, IDXW'($urandom), $urandom,
                 ($urandom % 2) == 0, ($urandom % 5) == 0,
                 NSRC'($urandom), si,
                 ($urandom % 3) == 0, IDXW'($urandom), $urandom, IDXW'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule